// File: doc/BRIEF.md
# SIMD Saturating Variable Shifter

This block is a registered vector datapath. It shifts every lane of a packed operand `opa` by its own signed amount. Each amount comes from the matching lane of a second operand `opb`. A positive amount shifts the lane left, with saturation when the result leaves the lane's range. A negative amount shifts the lane right and drops the bits that fall off, with no rounding. The lane width can be 8, 16, 32 or 64 bits. Lanes can be read as signed or unsigned. The vector can be 64 or 128 bits wide.

Operands are presented with `in_valid`. The merged result appears one clock edge later, together with `out_valid`. A sticky flag records that some lane saturated. The flag stays set until `sat_clear` is asserted.

Top module: `simd_qshift`

## Requirements
- R1: The shift amount of each lane is bits [7:0] of the matching lane of `opb`, read as a two's-complement byte. An amount of 0 or more shifts the `opa` lane left by that many bits.
- R2: A negative amount shifts right by its magnitude, with truncation. In signed mode (`is_unsigned`=0) the shift is arithmetic. In unsigned mode it fills with zeros.
- R3: A right shift by the lane width or more gives all ones (-1) for a negative signed lane. It gives 0 in every other case.
- R4: `esize` selects the lane width: 2'b00 is 8 bits, 2'b01 is 16, 2'b10 is 32 and 2'b11 is 64.
- R5: A signed left shift whose exact result is outside [-2^(w-1), 2^(w-1)-1] is clamped to the nearest bound, and the lane counts as saturated. This includes any left shift by w or more of a nonzero value.
- R6: An unsigned left shift whose exact result is at least 2^w is clamped to 2^w-1, and the lane counts as saturated.
- R7: A lane whose `opa` value is zero gives zero and never saturates, whatever its amount.
- R8: With `quad`=0, only the low 64 bits take part. `result[127:64]` is zero and lanes there cannot saturate.
- R9: `sat_flag` sets on any accepted operation in which some lane saturates. It then stays set until `sat_clear` is asserted. When a clear and a saturation fall in the same cycle, the flag ends up set.
- R10: `result` and `out_valid` update on the clock edge that samples `in_valid`=1. `result` holds while `in_valid`=0. Reset clears `result`, `out_valid` and `sat_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| quad | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| is_unsigned | input | 1 | 1: `opa` and result lanes unsigned |
| esize | input | 2 | Lane width code |
| sat_clear | input | 1 | Clear the sticky saturation flag |
| opa | input | 128 | Values to shift |
| opb | input | 128 | Per-lane signed shift amounts in each lane's low byte |
| out_valid | output | 1 | Result register loaded on the previous edge |
| result | output | 128 | Shifted and saturated lanes |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Clearing the sticky flag and a new saturation can land on the same clock edge. The bench provokes this by asserting `sat_clear` together with an operation that saturates. It expects the flag to be set afterwards. The same clear paired with a non-saturating operation must leave the flag low, so every swept vector drives `sat_clear`, and the flag then reports that vector's saturation alone. Sweeps cover every 8-bit value under a band of amounts on both sides of zero, plus pseudo-random lanes at every width, signedness and vector width, checked against an arithmetic model that doubles or halves one step at a time.

// File: rtl/simd_qshift.sv
module simd_qshift #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             quad,
  input  logic             is_unsigned,
  input  logic [1:0]       esize,
  input  logic             sat_clear,
  input  logic [VEC_W-1:0] opa,
  input  logic [VEC_W-1:0] opb,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             sat_flag
);
  localparam int HALF_W = VEC_W / 2;

  function automatic logic [64:0] lane_op(input logic [63:0] v, input logic [7:0] c,
                                          input logic [6:0] w, input logic uns);
    logic [63:0]  mask, maxv, minv, r;
    logic [127:0] ext, sh, top;
    logic [7:0]   mag;
    logic         neg, sat, ok;
    mask = (w == 7'd64) ? '1 : ((64'd1 << w) - 64'd1);
    neg  = !uns && (((v >> (w - 7'd1)) & 64'd1) != 64'd0);
    ext  = neg ? {64'hFFFF_FFFF_FFFF_FFFF, v | ~mask} : {64'd0, v & mask};
    maxv = uns ? mask : (mask >> 1);
    minv = uns ? 64'd0 : (mask & ~(mask >> 1));
    sat  = 1'b0;
    r    = 64'd0;
    mag  = 8'd0;
    sh   = 128'd0;
    top  = 128'd0;
    ok   = 1'b1;
    if ((v & mask) == 64'd0) begin
      r = 64'd0;
    end else if (!c[7]) begin
      if (c >= {1'b0, w}) begin
        sat = 1'b1;
        r   = neg ? minv : maxv;
      end else begin
        sh = ext << c;
        if (uns) begin
          ok = (sh >> w) == 128'd0;
        end else begin
          top = $signed(sh) >>> (w - 7'd1);
          ok  = (top == 128'd0) || (top == '1);
        end
        sat = !ok;
        r   = ok ? (sh[63:0] & mask) : (neg ? minv : maxv);
      end
    end else begin
      mag = 8'd0 - c;
      if (mag >= {1'b0, w}) r = neg ? mask : 64'd0;
      else begin
        sh = $signed(ext) >>> mag;
        r  = sh[63:0] & mask;
      end
    end
    return {sat, r};
  endfunction

  logic [VEC_W-1:0] res_s [4];
  logic [15:0]      sat_s [4];

  for (genvar s = 0; s < 4; s++) begin : g_size
    localparam int W = 8 << s;
    localparam int N = VEC_W / W;
    logic [VEC_W-1:0] res;
    logic [15:0]      sat;
    for (genvar j = 0; j < 16; j++) begin : g_lane
      if (j < N) begin : g_on
        logic [64:0] o;
        logic        en;
        logic        unused_hi;
        assign en  = quad || (j * W < HALF_W);
        assign o   = lane_op(64'(opa[j*W +: W]), opb[j*W +: 8], 7'(W), is_unsigned);
        assign res[j*W +: W] = en ? o[W-1:0] : '0;
        assign sat[j] = en & o[64];
        assign unused_hi = ^o;
      end else begin : g_off
        assign sat[j] = 1'b0;
      end
    end
    assign res_s[s] = res;
    assign sat_s[s] = sat;
  end

  logic [VEC_W-1:0] res_c;
  logic             any_sat;
  logic             unused_b;
  assign res_c    = res_s[esize];
  assign any_sat  = in_valid && (|sat_s[esize]);
  assign unused_b = ^opb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_c;
      sat_flag <= any_sat | (sat_flag & ~sat_clear);
    end
  end

  assert_half_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !quad) |=> (result[VEC_W-1:HALF_W] == '0));
  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clear) |=> sat_flag);
  assert_clear_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clear && !in_valid) |=> !sat_flag);
  assert_zero_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opa == '0 && sat_clear) |=> (result == '0 && !sat_flag));
  assert_valid_pipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
endmodule

// File: tb/test_simd_qshift.sv
module test_simd_qshift;
  localparam int PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, quad = 1'b1, is_unsigned = 1'b0, sat_clear = 1'b0;
  logic [1:0] esize = 2'b00;
  logic [127:0] opa = '0, opb = '0;
  logic out_valid, sat_flag;
  logic [127:0] result;
  int errors = 0, checks = 0;
  logic flag_model = 1'b0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  simd_qshift i_simd_qshift (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .quad(quad),
    .is_unsigned(is_unsigned), .esize(esize), .sat_clear(sat_clear), .opa(opa), .opb(opb),
    .out_valid(out_valid), .result(result), .sat_flag(sat_flag));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [63:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  // Arithmetic model: step-by-step doubling or halving on a wide signed value.
  task automatic ref_lane(input logic [63:0] val, input logic [7:0] cnt, input int w,
                          input logic uns, output logic [63:0] r, output logic sat);
    logic signed [129:0] x, hi, lo;
    logic [63:0] mask;
    int c;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    x = 130'(val & mask);
    if (!uns && val[w-1]) x = x - (130'sd1 <<< w);
    hi = (130'sd1 <<< (uns ? w : w - 1)) - 130'sd1;
    lo = uns ? 130'sd0 : -(130'sd1 <<< (w - 1));
    c = int'($signed(cnt));
    sat = 1'b0;
    if (c >= 0) begin
      for (int k = 0; k < c; k++) begin
        if (x == 0) break;
        x = x * 2;
        if (x > hi) begin x = hi; sat = 1'b1; break; end
        if (x < lo) begin x = lo; sat = 1'b1; break; end
      end
    end else begin
      for (int k = 0; k < -c; k++) x = x >>> 1;
    end
    r = x[63:0] & mask;
  endtask

  task automatic apply(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                       input logic u, input logic q, input logic clr, input string tag);
    logic [127:0] exp_r;
    logic exp_s, ls;
    logic [63:0] lr;
    int w, nl;
    w = 8 << sz;
    nl = (q ? 128 : 64) / w;
    exp_r = '0;
    exp_s = 1'b0;
    for (int j = 0; j < nl; j++) begin
      logic [127:0] av, bv;
      av = a >> (j * w);
      bv = b >> (j * w);
      ref_lane(av[63:0], bv[7:0], w, u, lr, ls);
      exp_r = exp_r | ({64'd0, lr} << (j * w));
      exp_s = exp_s | ls;
    end
    flag_model = exp_s | (flag_model & ~clr);
    opa = a; opb = b; esize = sz; is_unsigned = u; quad = q; sat_clear = clr; in_valid = 1'b1;
    @(negedge clk);
    checks++;
    if (result !== exp_r || sat_flag !== flag_model || out_valid !== 1'b1) begin
      errors++;
      $display("FAIL %s sz=%0d u=%0d q=%0d: result=%h flag=%b valid=%b expected result=%h flag=%b",
               tag, sz, u, q, result, sat_flag, out_valid, exp_r, flag_model);
    end
  endtask

  task automatic idle_check(input logic clr, input logic [127:0] exp_r, input logic exp_f, input string tag);
    in_valid = 1'b0; sat_clear = clr; opa = ~opa;
    @(negedge clk);
    checks++;
    if (result !== exp_r || sat_flag !== exp_f || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: result=%h flag=%b valid=%b expected result=%h flag=%b valid=0",
               tag, result, sat_flag, out_valid, exp_r, exp_f);
    end
    flag_model = exp_f;
  endtask

  initial begin
    #(PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] a, b, held;
    repeat (2) @(negedge clk);
    checks++;
    if (result !== '0 || sat_flag !== 1'b0 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: result=%h flag=%b valid=%b expected 0 0 0", result, sat_flag, out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R5 R6 R7: every 8-bit value against amounts on both sides of zero
    for (int u = 0; u < 2; u++)
      for (int v = 0; v < 256; v++)
        for (int k = -10; k <= 10; k++) begin
          for (int j = 0; j < 16; j++) begin
            a[j*8 +: 8] = 8'(v + 37 * j);
            b[j*8 +: 8] = 8'(k + j - 8);
          end
          apply(a, b, 2'b00, 1'(u), 1'b1, 1'b1, "R1/R2/R3/R5/R6/R7 sweep8");
        end

    // R4 R8: pseudo-random lanes at every width, signedness and vector width
    for (int sz = 0; sz < 4; sz++)
      for (int m = 0; m < 4; m++)
        for (int n = 0; n < 300; n++) begin
          int w;
          w = 8 << sz;
          a = {rnd(), rnd()};
          if (n % 5 == 0) a = a >> (rnd() % 128);
          b = {rnd(), rnd()};
          for (int j = 0; j < 128 / w; j++)
            if (n % 8 != 7) b[j*w +: 8] = 8'(int'(rnd() % 64'(2*w + 9)) - (w + 4));
          apply(a, b, 2'(sz), 1'(m & 1), 1'(m >> 1), 1'b1, "R4/R8 random");
        end

    // R7: zero operand with extreme amounts
    apply('0, {16{8'h7F}}, 2'b00, 1'b0, 1'b1, 1'b1, "R7 zero left127");
    apply('0, {16{8'h80}}, 2'b11, 1'b1, 1'b1, 1'b1, "R7 zero right128");
    // R5 R3: 64-bit signed corners
    apply({64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001},
          {64'd1, 64'd63}, 2'b11, 1'b0, 1'b1, 1'b1, "R5 s64 clamp");
    apply({64'h8000_0000_0000_0000, 64'h7000_0000_0000_0000},
          {64'h80, 64'hC0}, 2'b11, 1'b0, 1'b1, 1'b1, "R3 s64 right far");
    // R6: unsigned 16-bit overflow by one bit
    apply({8{16'h8000}}, {8{16'h0001}}, 2'b01, 1'b1, 1'b1, 1'b1, "R6 u16 clamp");

    // R8: saturating lanes only in the upper half, 64-bit mode
    apply({64'hFFFF_FFFF_FFFF_FFFF, 64'd0}, {64'h0707_0707_0707_0707, 64'd0},
          2'b00, 1'b1, 1'b0, 1'b1, "R8 upper ignored");

    // R9: sticky set, hold across clean operations, clear on idle
    apply({16{8'h40}}, {16{8'h02}}, 2'b00, 1'b0, 1'b1, 1'b1, "R9 set");
    apply({16{8'h01}}, {16{8'h01}}, 2'b00, 1'b0, 1'b1, 1'b0, "R9 hold1");
    apply({16{8'h10}}, {16{8'hFF}}, 2'b00, 1'b1, 1'b1, 1'b0, "R9 hold2");
    held = result;
    idle_check(1'b0, held, 1'b1, "R9/R10 idle hold");
    idle_check(1'b1, held, 1'b0, "R9 clear idle");
    // R9: clear together with saturation keeps flag set
    apply({16{8'h40}}, {16{8'h03}}, 2'b00, 1'b0, 1'b1, 1'b1, "R9 clear+sat");
    // R9: clear together with clean operation leaves flag low
    apply({16{8'h01}}, {16{8'h01}}, 2'b00, 1'b0, 1'b1, 1'b1, "R9 clear+clean");
    held = result;
    idle_check(1'b0, held, 1'b0, "R10 hold after valid");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule